// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block prepares the second operand for a 32-bit integer datapath. It takes an instruction word, the value of the operand register, the value of the amount register and the current carry flag. It returns the shifted or rotated operand and the carry bit that the shift produces. The block only decodes the fields of the instruction that concern the shift. Register reads, the arithmetic unit and the rest of instruction decode belong to neighbouring blocks.

The operand comes from one of three sources:
- **Rotated constant.** Instruction bit 25 set: an 8-bit constant, rotated right by an even amount.
- **Register, fixed amount.** Bit 25 clear and bit 4 clear: a register shifted by a 5-bit amount taken from the instruction.
- **Register, register amount.** Bit 25 clear and bit 4 set: a register shifted by the low byte of a second register.

The shift kind is taken from instruction bits 6:5. The codes are 00 left logical, 01 right logical, 10 right arithmetic and 11 rotate right. A zero fixed amount picks special cases: a right shift by 32, a sign fill, or a one-bit rotate through carry.

Decode and shifting are combinational. The operand and carry are captured on the rising clock edge, so a result appears one cycle after its inputs.

Top module: `opsh_operand`

## Requirements
- R1: A synchronous active-high reset clears the operand to 0 and the carry to 0. In every other cycle, the outputs show the result of the inputs sampled at the previous rising edge.
- R2: Rotated-constant form (bit 25 = 1). The operand is the zero-extended value of bits 7:0, rotated right by twice the value of bits 11:8. The carry is the incoming carry when that field is 0, and bit 31 of the operand otherwise.
- R3: Fixed-amount form (bit 25 = 0, bit 4 = 0), amount in bits 11:7, register value Rm. An amount of 1 to 31 shifts Rm as coded in bits 6:5, and the carry is the last bit shifted out. A left shift with amount 0 passes Rm unchanged and the incoming carry.
- R4: Fixed-amount right logical with amount 0 means a shift by 32: the operand is 0 and the carry is Rm bit 31.
- R5: Fixed-amount right arithmetic with amount 0 gives all ones when Rm bit 31 is 1 and all zeros otherwise. The carry is Rm bit 31.
- R6: Fixed-amount rotate with amount 0 is a one-bit rotate through carry: the operand is {carry_flag, Rm[31:1]} and the carry is Rm bit 0.
- R7: Register-amount form (bit 4 = 1). Only bits 7:0 of the amount register count. An amount of 0 passes Rm unchanged and passes the incoming carry.
- R8: Register-amount left or right logical shift:
  - amount exactly 32: the operand is 0, and the carry is Rm bit 0 for a left shift or Rm bit 31 for a right shift;
  - amount above 32: the operand is 0 and the carry is 0.
- R9: Register-amount right arithmetic with an amount of 32 or more fills every bit with Rm bit 31. The carry is Rm bit 31.
- R10: Register-amount rotate uses the amount modulo 32. A nonzero amount that is a multiple of 32 gives Rm unchanged, and the carry is Rm bit 31.
- R11: A register amount from 1 to 31 shifts exactly as a fixed amount of the same value does, operand and carry alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_word | input | 32 | Instruction word. Bits 25, 11:0 are used |
| rm_data | input | 32 | Value of the register to be shifted |
| rs_data | input | 32 | Value of the amount register. Bits 7:0 are used |
| carry_flag | input | 1 | Current carry flag |
| operand | output | 32 | Registered shifted operand |
| carry_out | output | 1 | Registered shifter carry |

## Verification
The block has one register stage, so any fault shows at the ports one cycle after the stimulus that exposes it.

Each kind of fault has its own signature:
- **Wrong shift kind or amount.** The operand is misplaced or wrongly filled.
- **Wrong special case.** A misdecoded special case either leaks Rm through where the operand should be 0 or a sign fill, or puts the wrong bit in bit 31 of a rotate through carry.
- **Wrong carry selection.** The carry is off by one bit position. This shows only when the neighbouring bits of Rm differ, so the stimulus uses alternating and single-bit patterns.

The register-amount cases at 0, 31, 32, 33 and above 255 separate the saturation rules from the wrap rule.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

    localparam int WORD_W    = 32;
    localparam int INSTR_W   = 32;
    localparam int BIT_CONST = 25;   // selects rotated-constant form
    localparam int BIT_REGAM = 4;    // selects register-supplied amount

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_type_e;

    typedef enum logic [2:0] {
        OP_PASS,
        OP_LSL,
        OP_LSR,
        OP_ASR,
        OP_ROR,
        OP_RRX,
        OP_ZERO
    } op_kind_e;

endpackage

// File: rtl/opsh_decode.sv
module opsh_decode
    import opsh_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic [INSTR_W-1:0]         instr,
    input  logic [DATA_W-1:0]          rs_data,
    output op_kind_e                   kind,
    output logic [$clog2(DATA_W):0]    amt,
    output logic                       use_const,
    output logic [DATA_W-1:0]          const_val
);

    localparam int SH_W  = $clog2(DATA_W);
    localparam int AMT_W = SH_W + 1;
    localparam logic [AMT_W-1:0] FULL_AMT  = AMT_W'(DATA_W);
    localparam logic [7:0]       FULL_BYTE = 8'(DATA_W);

    shift_type_e      sh_type;
    logic [4:0]       fix_amt;
    logic [7:0]       reg_amt;
    logic             unused_bits;

    assign sh_type     = shift_type_e'(instr[6:5]);
    assign fix_amt     = instr[11:7];
    assign reg_amt     = rs_data[7:0];
    assign use_const   = instr[BIT_CONST];
    assign const_val   = DATA_W'(instr[7:0]);
    assign unused_bits = ^{instr[INSTR_W-1:BIT_CONST+1], instr[BIT_CONST-1:12],
                           rs_data[DATA_W-1:8]};

    always_comb begin
        kind = OP_PASS;
        amt  = '0;
        if (instr[BIT_CONST]) begin
            amt  = AMT_W'({instr[11:8], 1'b0});
            kind = (instr[11:8] == 4'd0) ? OP_PASS : OP_ROR;
        end else if (!instr[BIT_REGAM]) begin
            unique case (sh_type)
                SH_LSL: begin
                    kind = (fix_amt == 5'd0) ? OP_PASS : OP_LSL;
                    amt  = AMT_W'(fix_amt);
                end
                SH_LSR: begin
                    kind = OP_LSR;
                    amt  = (fix_amt == 5'd0) ? FULL_AMT : AMT_W'(fix_amt);
                end
                SH_ASR: begin
                    kind = OP_ASR;
                    amt  = (fix_amt == 5'd0) ? FULL_AMT : AMT_W'(fix_amt);
                end
                default: begin
                    kind = (fix_amt == 5'd0) ? OP_RRX : OP_ROR;
                    amt  = AMT_W'(fix_amt);
                end
            endcase
        end else if (reg_amt != 8'd0) begin
            unique case (sh_type)
                SH_LSL: begin
                    kind = (reg_amt > FULL_BYTE) ? OP_ZERO : OP_LSL;
                    amt  = reg_amt[AMT_W-1:0];
                end
                SH_LSR: begin
                    kind = (reg_amt > FULL_BYTE) ? OP_ZERO : OP_LSR;
                    amt  = reg_amt[AMT_W-1:0];
                end
                SH_ASR: begin
                    kind = OP_ASR;
                    amt  = (reg_amt >= FULL_BYTE) ? FULL_AMT : reg_amt[AMT_W-1:0];
                end
                default: begin
                    kind = OP_ROR;
                    amt  = AMT_W'(reg_amt[SH_W-1:0]);
                end
            endcase
        end
    end

endmodule

// File: rtl/opsh_core.sv
module opsh_core
    import opsh_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  op_kind_e                   kind,
    input  logic [$clog2(DATA_W):0]    amt,
    input  logic [DATA_W-1:0]          src,
    input  logic                       cin,
    output logic [DATA_W-1:0]          res,
    output logic                       cout
);

    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W:0]     ext_left;
    logic [DATA_W:0]     ext_right;
    logic [DATA_W:0]     ext_arith;
    logic [2*DATA_W-1:0] rot_pair;
    logic [DATA_W-1:0]   rot_res;
    logic [DATA_W:0]     unused_rot;

    // one guard bit beyond the word holds the last bit shifted out
    assign ext_left  = {1'b0, src} << amt;
    assign ext_right = {src, 1'b0} >> amt;
    assign ext_arith = $signed({src, 1'b0}) >>> amt;
    assign rot_pair  = {src, src} >> amt[SH_W-1:0];
    assign rot_res   = rot_pair[DATA_W-1:0];
    assign unused_rot = {rot_pair[2*DATA_W-1:DATA_W], amt[SH_W]};

    always_comb begin
        res  = src;
        cout = cin;
        unique case (kind)
            OP_LSL: begin
                res  = ext_left[DATA_W-1:0];
                cout = ext_left[DATA_W];
            end
            OP_LSR: begin
                res  = ext_right[DATA_W:1];
                cout = ext_right[0];
            end
            OP_ASR: begin
                res  = ext_arith[DATA_W:1];
                cout = ext_arith[0];
            end
            OP_ROR: begin
                res  = rot_res;
                cout = rot_res[DATA_W-1];
            end
            OP_RRX: begin
                res  = {cin, src[DATA_W-1:1]};
                cout = src[0];
            end
            OP_ZERO: begin
                res  = '0;
                cout = 1'b0;
            end
            default: begin
                res  = src;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/opsh_operand.sv
module opsh_operand
    import opsh_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic [DATA_W-1:0]  rm_data,
    input  logic [DATA_W-1:0]  rs_data,
    input  logic               carry_flag,
    output logic [DATA_W-1:0]  operand,
    output logic               carry_out
);

    localparam int AMT_W = $clog2(DATA_W) + 1;

    typedef struct packed {
        logic [DATA_W-1:0] opnd;
        logic              cy;
    } stage_t;

    op_kind_e            dec_kind;
    logic [AMT_W-1:0]    dec_amt;
    logic                dec_const;
    logic [DATA_W-1:0]   dec_cval;
    logic [DATA_W-1:0]   core_src;
    logic [DATA_W-1:0]   core_res;
    logic                core_cy;
    stage_t              stage_d;
    stage_t              stage_q;

    opsh_decode #(.DATA_W(DATA_W)) i_decode (
        .instr     (instr_word),
        .rs_data   (rs_data),
        .kind      (dec_kind),
        .amt       (dec_amt),
        .use_const (dec_const),
        .const_val (dec_cval)
    );

    assign core_src = dec_const ? dec_cval : rm_data;

    opsh_core #(.DATA_W(DATA_W)) i_core (
        .kind (dec_kind),
        .amt  (dec_amt),
        .src  (core_src),
        .cin  (carry_flag),
        .res  (core_res),
        .cout (core_cy)
    );

    always_comb begin
        stage_d.opnd = core_res;
        stage_d.cy   = core_cy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign operand   = stage_q.opnd;
    assign carry_out = stage_q.cy;

    // form qualifiers on the ports, used by the checks below
    logic fixed_form;
    logic reg_form;
    assign fixed_form = !instr_word[BIT_CONST] && !instr_word[BIT_REGAM];
    assign reg_form   = !instr_word[BIT_CONST] &&  instr_word[BIT_REGAM];

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (operand == '0) && !carry_out); // R1

    AST_CONST_NO_ROT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr_word[BIT_CONST]) && $past(instr_word[11:8]) == 4'd0)
        |-> (operand == DATA_W'($past(instr_word[7:0]))) && (carry_out == $past(carry_flag))); // R2

    AST_FIX_LSR_FULL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fixed_form) && $past(instr_word[6:5]) == 2'b01
         && $past(instr_word[11:7]) == 5'd0)
        |-> (operand == '0) && (carry_out == $past(rm_data[DATA_W-1]))); // R4

    AST_FIX_ASR_FILL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fixed_form) && $past(instr_word[6:5]) == 2'b10
         && $past(instr_word[11:7]) == 5'd0)
        |-> (operand == {DATA_W{$past(rm_data[DATA_W-1])}})
            && (carry_out == $past(rm_data[DATA_W-1]))); // R5

    AST_RRX_INSERT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fixed_form) && $past(instr_word[6:5]) == 2'b11
         && $past(instr_word[11:7]) == 5'd0)
        |-> (operand == {$past(carry_flag), $past(rm_data[DATA_W-1:1])})
            && (carry_out == $past(rm_data[0]))); // R6

    AST_REG_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_form) && $past(rs_data[7:0]) == 8'd0)
        |-> (operand == $past(rm_data)) && (carry_out == $past(carry_flag))); // R7

    AST_REG_OVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_form) && !$past(instr_word[6])
         && $past(rs_data[7:0]) > 8'd32)
        |-> (operand == '0) && !carry_out); // R8

    AST_REG_ASR_SAT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_form) && $past(instr_word[6:5]) == 2'b10
         && $past(rs_data[7:0]) >= 8'd32)
        |-> (operand == {DATA_W{$past(rm_data[DATA_W-1])}})
            && (carry_out == $past(rm_data[DATA_W-1]))); // R9

endmodule

// File: tb/test_opsh_operand.sv
module test_opsh_operand;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr_word;
    logic [31:0] rm_data;
    logic [31:0] rs_data;
    logic        carry_flag;
    logic [31:0] operand;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    opsh_operand i_opsh_operand (
        .clk        (clk),
        .rst        (rst),
        .instr_word (instr_word),
        .rm_data    (rm_data),
        .rs_data    (rs_data),
        .carry_flag (carry_flag),
        .operand    (operand),
        .carry_out  (carry_out)
    );

    // instruction builders; type codes 0 LSL, 1 LSR, 2 ASR, 3 ROR
    function automatic logic [31:0] mk_const(input int rot, input int imm8);
        return (32'd1 << 25) | (32'(rot & 15) << 8) | 32'(imm8 & 255);
    endfunction
    function automatic logic [31:0] mk_fix(input int typ, input int amt);
        return (32'(amt & 31) << 7) | (32'(typ & 3) << 5);
    endfunction
    function automatic logic [31:0] mk_reg(input int typ);
        return (32'(typ & 3) << 5) | (32'd1 << 4) | (32'd5 << 8);
    endfunction

    // plain shift of 1..32 positions, bit by bit; returns {carry, value}
    function automatic logic [32:0] shift_by(input int typ, input logic [31:0] v, input int n);
        logic [31:0] r;
        logic        c;
        for (int i = 0; i < 32; i++) begin
            case (typ)
                0:       r[i] = (i >= n) ? v[i-n] : 1'b0;
                1:       r[i] = (i + n < 32) ? v[i+n] : 1'b0;
                2:       r[i] = (i + n < 32) ? v[i+n] : v[31];
                default: r[i] = v[(i+n)%32];
            endcase
        end
        c = (typ == 0) ? v[32-n] : v[n-1];
        return {c, r};
    endfunction

    function automatic logic [32:0] model(input logic [31:0] iw, input logic [31:0] rm,
                                          input logic [31:0] rs, input logic cin);
        int typ;
        int n;
        logic [31:0] r;
        typ = int'(iw[6:5]);
        if (iw[25]) begin
            n = 2 * int'(iw[11:8]);
            if (n == 0) return {cin, 24'd0, iw[7:0]};
            for (int i = 0; i < 32; i++) r[i] = ((i + n) % 32 < 8) ? iw[(i+n)%32] : 1'b0;
            return {r[31], r};
        end
        if (!iw[4]) begin
            n = int'(iw[11:7]);
            if (n != 0) return shift_by(typ, rm, n);
            case (typ)
                0:       return {cin, rm};
                1:       return {rm[31], 32'd0};
                2:       return {rm[31], {32{rm[31]}}};
                default: return {rm[0], cin, rm[31:1]};
            endcase
        end
        n = int'(rs[7:0]);
        if (n == 0) return {cin, rm};
        case (typ)
            0, 1:    return (n > 32) ? 33'd0 : shift_by(typ, rm, n);
            2:       return shift_by(2, rm, (n > 32) ? 32 : n);
            default: return ((n % 32) == 0) ? {rm[31], rm} : shift_by(3, rm, n % 32);
        endcase
    endfunction

    task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got op=%08h c=%0b, expected op=%08h c=%0b",
                     tag, got[31:0], got[32], exp[31:0], exp[32]);
        end
    endtask

    // drive at falling edge, result registered at the rising edge, read at next falling edge
    task automatic run(input string tag, input logic [31:0] iw, input logic [31:0] rm,
                       input logic [31:0] rs, input logic cin);
        @(negedge clk);
        instr_word = iw; rm_data = rm; rs_data = rs; carry_flag = cin;
        @(negedge clk);
        check(tag, {carry_out, operand}, model(iw, rm, rs, cin));
    endtask

    task automatic run_exp(input string tag, input logic [31:0] iw, input logic [31:0] rm,
                           input logic [31:0] rs, input logic cin, input logic [32:0] exp);
        @(negedge clk);
        instr_word = iw; rm_data = rm; rs_data = rs; carry_flag = cin;
        @(negedge clk);
        check(tag, {carry_out, operand}, exp);
    endtask

    task automatic t_reset;
        run_exp("R1 prior value", mk_fix(0, 0), 32'hDEADBEEF, 32'd0, 1'b1, {1'b1, 32'hDEADBEEF});
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears", {carry_out, operand}, 33'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 result after reset", {carry_out, operand}, {1'b1, 32'hDEADBEEF});
    endtask

    task automatic t_const;
        run_exp("R2 rot 0 keeps carry", mk_const(0, 8'hA5), 32'd0, 32'd0, 1'b1, {1'b1, 32'h000000A5});
        run_exp("R2 rot 4", mk_const(4, 8'hFF), 32'd0, 32'd0, 1'b0, {1'b1, 32'hFF000000});
        run_exp("R2 rot 1", mk_const(1, 8'h01), 32'd0, 32'd0, 1'b0, {1'b0, 32'h40000000});
        for (int r = 0; r < 16; r++)
            run("R2 rotate sweep", mk_const(r, 8'h81), 32'd0, 32'd0, r[0]);
    endtask

    task automatic t_fixed;
        run_exp("R3 lsl 0 pass", mk_fix(0, 0), 32'h12345678, 32'd0, 1'b0, {1'b0, 32'h12345678});
        run_exp("R3 lsl 1", mk_fix(0, 1), 32'h80000001, 32'd0, 1'b0, {1'b1, 32'h00000002});
        run_exp("R3 asr 4", mk_fix(2, 4), 32'h80000008, 32'd0, 1'b0, {1'b1, 32'hF8000000});
        for (int t = 0; t < 4; t++)
            for (int a = 1; a < 32; a += 3) begin
                run("R3 sweep A", mk_fix(t, a), 32'hA5C3_0F96, 32'd0, 1'b0);
                run("R3 sweep B", mk_fix(t, a), 32'h8000_0001 << (a % 5), 32'd0, 1'b1);
            end
    endtask

    task automatic t_fix_special;
        run_exp("R4 lsr 32 msb1", mk_fix(1, 0), 32'h80000000, 32'd0, 1'b0, {1'b1, 32'd0});
        run_exp("R4 lsr 32 msb0", mk_fix(1, 0), 32'h7FFFFFFF, 32'd0, 1'b1, {1'b0, 32'd0});
        run_exp("R5 asr fill ones", mk_fix(2, 0), 32'h80000000, 32'd0, 1'b0, {1'b1, 32'hFFFFFFFF});
        run_exp("R5 asr fill zeros", mk_fix(2, 0), 32'h7FFFFFFF, 32'd0, 1'b1, {1'b0, 32'd0});
        run_exp("R6 rrx carry 1", mk_fix(3, 0), 32'h00000003, 32'd0, 1'b1, {1'b1, 32'h80000001});
        run_exp("R6 rrx carry 0", mk_fix(3, 0), 32'hFFFFFFFE, 32'd0, 1'b0, {1'b0, 32'h7FFFFFFF});
    endtask

    task automatic t_reg;
        run_exp("R7 amount 0 pass", mk_reg(0), 32'hCAFEF00D, 32'hFFFFFF00, 1'b1, {1'b1, 32'hCAFEF00D});
        run_exp("R7 high bits ignored", mk_reg(1), 32'h000000F0, 32'hABCDEF04, 1'b0, {1'b0, 32'h0000000F});
        run_exp("R8 lsl 32", mk_reg(0), 32'h00000001, 32'd32, 1'b0, {1'b1, 32'd0});
        run_exp("R8 lsr 32", mk_reg(1), 32'h80000000, 32'd32, 1'b0, {1'b1, 32'd0});
        run_exp("R8 lsl 33", mk_reg(0), 32'hFFFFFFFF, 32'd33, 1'b1, {1'b0, 32'd0});
        run_exp("R8 lsr 255", mk_reg(1), 32'hFFFFFFFF, 32'd255, 1'b1, {1'b0, 32'd0});
        run_exp("R9 asr 32", mk_reg(2), 32'h80000000, 32'd32, 1'b0, {1'b1, 32'hFFFFFFFF});
        run_exp("R9 asr 200", mk_reg(2), 32'h7FFFFFFF, 32'd200, 1'b1, {1'b0, 32'd0});
        run_exp("R10 ror 32", mk_reg(3), 32'h80000001, 32'd32, 1'b0, {1'b1, 32'h80000001});
        run_exp("R10 ror 36", mk_reg(3), 32'h0000001F, 32'd36, 1'b0, {1'b1, 32'hF0000001});
        run_exp("R10 ror 64", mk_reg(3), 32'h40000000, 32'd64, 1'b1, {1'b0, 32'h40000000});
        for (int t = 0; t < 4; t++)
            for (int a = 1; a < 32; a += 5) begin
                run_exp("R11 matches fixed", mk_reg(t), 32'h9E37_79B9, 32'(a), 1'b0,
                        model(mk_fix(t, a), 32'h9E37_79B9, 32'd0, 1'b0));
                run("R11 sweep", mk_reg(t), 32'h0F0F_8001, 32'(a + 256), 1'b1);
            end
    endtask

    initial begin
        rst = 1'b1; instr_word = '0; rm_data = '0; rs_data = '0; carry_flag = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset state", {carry_out, operand}, 33'd0);
        rst = 1'b0;
        t_reset();
        t_const();
        t_fixed();
        t_fix_special();
        t_reg();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running, expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule